// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block collects single-cycle event pulses from up to sixteen internal sources into a pending-status register. It combines them with a per-source mask into one interrupt line towards a host processor. The host reaches the block through a small synchronous register port: an address, a write strobe with write data, and a read strobe whose data appears on the next clock.

The mask can be replaced in one write. It can also be edited bit by bit through a set alias and a clear alias. Pending bits can be inspected without disturbing them, drained in one clearing read, or retired one by one through a write-one-to-acknowledge register. A fresh event always takes priority over a clear that lands on the same bit in the same cycle, so no event is lost. The polarity of the interrupt line is chosen by a static input.

Top module: `hisc_top`

## Requirements
- R1: After a synchronous active-low reset the mask reads 0x0001, so only source 0 is blocked, and every pending bit is 0.
- R2: A write to address 0x0 replaces the whole mask, and a read of address 0x0 returns it. A mask bit at 1 blocks its source from the interrupt line.
- R3: A write to address 0x1 sets every mask bit written as 1 and leaves the bits written as 0 unchanged.
- R4: A write to address 0x2 clears every mask bit written as 1 and leaves the bits written as 0 unchanged.
- R5: A read of address 0x3 returns the pending bits and leaves them unchanged.
- R6: A read of address 0x4 returns the pending bits and clears all of them at the same clock edge.
- R7: A write to address 0x5 clears each pending bit written as 1. Bits written as 0 are not affected.
- R8: A source pulse on a bit in the same cycle as a clearing read or an acknowledge of that bit leaves that bit pending.
- R9: Pending bits are captured whatever the mask holds, so masked events are visible in both status reads.
- R10: The interrupt line is asserted when any pending bit has a 0 mask bit. It is high when asserted if the polarity input is 0, and low when asserted if the polarity input is 1. It follows the registers with no further clock delay.
- R11: Read data is registered and appears one cycle after the read strobe. Reads of the write-only addresses 0x1, 0x2 and 0x5 return 0. Writes to the status addresses 0x3 and 0x4 change nothing.
- R12: Source positions are fixed, and source i sets pending bit i. Receive buffer 0 is bit 0, transmit data is bit 1, command complete is bit 10 and initialization complete is bit 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_evt | input | 16 | One-cycle event pulses, one per source |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_re |
| irq_pol_low | input | 1 | 1 selects an active-low interrupt line |
| host_irq | output | 1 | Interrupt towards the host |

## Verification
Two functions can fall in the same cycle: a source pulse, and a clear of the same pending bit. The clear can come either from the clearing read or from an acknowledge write. The bench drives a pulse on bit 4 together with each kind of clear in a single vector. It then reads status without side effects on the next cycle and expects bit 4 to still be pending. For the clearing read it also expects the returned word to hold the bit's value from before the edge.

// File: rtl/hisc_pkg.sv
// Package: shared constants and types for the host interrupt status controller.
// Assumes a 4-bit register address; offsets are decoded by hisc_decode.
package hisc_pkg;

    localparam int unsigned HISC_ADDR_W = 4;

    // Register offsets seen by the host.
    localparam logic [HISC_ADDR_W-1:0] OFS_MASK     = 4'h0;
    localparam logic [HISC_ADDR_W-1:0] OFS_MASK_SET = 4'h1;
    localparam logic [HISC_ADDR_W-1:0] OFS_MASK_CLR = 4'h2;
    localparam logic [HISC_ADDR_W-1:0] OFS_PEEK     = 4'h3;
    localparam logic [HISC_ADDR_W-1:0] OFS_DRAIN    = 4'h4;
    localparam logic [HISC_ADDR_W-1:0] OFS_ACK      = 4'h5;

    // Fixed source bit positions (R12).
    localparam int unsigned SRC_RXBUF0    = 0;
    localparam int unsigned SRC_TXDATA    = 1;
    localparam int unsigned SRC_CMD_DONE  = 10;
    localparam int unsigned SRC_INIT_DONE = 14;

    // One strobe per register action; at most one is high in a cycle.
    typedef struct packed {
        logic mask_wr;
        logic mask_set;
        logic mask_clr;
        logic peek_rd;
        logic drain_rd;
        logic ack_wr;
    } hisc_strobe_t;

endpackage

// File: rtl/hisc_decode.sv
// Module: hisc_decode
// Turns the bus address and strobes into one action strobe per register.
// Assumes write and read strobes are not both high in one cycle; if they are,
// both actions decode, each on its own address.
module hisc_decode
    import hisc_pkg::*;
(
    input  logic                   we,
    input  logic                   re,
    input  logic [HISC_ADDR_W-1:0] addr,
    output hisc_strobe_t           stb
);

    // Purpose: compare the address against each register offset.
    always_comb begin
        stb          = '0;
        stb.mask_wr  = we && (addr == OFS_MASK);
        stb.mask_set = we && (addr == OFS_MASK_SET);
        stb.mask_clr = we && (addr == OFS_MASK_CLR);
        stb.ack_wr   = we && (addr == OFS_ACK);
        stb.peek_rd  = re && (addr == OFS_PEEK);
        stb.drain_rd = re && (addr == OFS_DRAIN);
    end

endmodule

// File: rtl/hisc_mask_reg.sv
// Module: hisc_mask_reg
// Holds the interrupt mask. It can be replaced whole, or edited through
// set and clear aliases that touch only the bits written as 1.
// Assumes at most one of the three write strobes is high per cycle.
module hisc_mask_reg #(
    parameter int unsigned NUM_SRC = 16,
    parameter logic [NUM_SRC-1:0] RST_VAL = NUM_SRC'(1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_all,
    input  logic               wr_set,
    input  logic               wr_clr,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] mask
);

    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] mask_d;

    // Purpose: select the next mask value from the active write strobe.
    always_comb begin
        mask_d = mask_q;
        if (wr_all)      mask_d = wbits;
        else if (wr_set) mask_d = mask_q | wbits;
        else if (wr_clr) mask_d = mask_q & ~wbits;
    end

    // Purpose: register the mask with synchronous reset to RST_VAL.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= RST_VAL;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;

    // R1: reset loads the documented mask value.
    assert_mask_reset_R1: assert property (@(posedge clk)
        !rst_n |=> mask == RST_VAL);

    // R2: a full write is visible next cycle.
    assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_all |=> mask == $past(wbits));

    // R3: set alias raises written ones and keeps the other bits.
    assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask & $past(wbits)) == $past(wbits)) &&
                   ((mask & ~$past(wbits)) == ($past(mask) & ~$past(wbits))));

    // R4: clear alias drops written ones and keeps the other bits.
    assert_mask_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask & $past(wbits)) == '0) &&
                   ((mask & ~$past(wbits)) == ($past(mask) & ~$past(wbits))));

endmodule

// File: rtl/hisc_status_reg.sv
// Module: hisc_status_reg
// Latches event pulses into pending bits regardless of the mask. A drain
// clears all bits, and an acknowledge clears the bits written as 1. A pulse
// in the same cycle as a clear of the same bit keeps that bit pending.
module hisc_status_reg #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic               drain,
    input  logic               ack_we,
    input  logic [NUM_SRC-1:0] ack_bits,
    output logic [NUM_SRC-1:0] pend
);

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] clr_vec;

    // Purpose: form the per-bit clear request from drain and acknowledge.
    always_comb begin
        clr_vec = '0;
        if (drain)       clr_vec = '1;
        else if (ack_we) clr_vec = ack_bits;
    end

    // Purpose: per-bit pending flops; a new event overrides a clear.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)      pend_q[i] <= 1'b0;
            else if (src[i]) pend_q[i] <= 1'b1;
            else if (clr_vec[i]) pend_q[i] <= 1'b0;
        end
    end

    assign pend = pend_q;

    // R1: reset empties the status.
    assert_status_reset_R1: assert property (@(posedge clk)
        !rst_n |=> pend == '0);

    // R8 and R9: every pulsed bit is pending on the next cycle.
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (src != '0) |=> (pend & $past(src)) == $past(src));

    // R6: a drain with no new events empties the status.
    assert_drain_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && src == '0) |=> pend == '0);

    // R7: acknowledged bits without a new event are gone, the rest are kept.
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !drain) |=>
            ((pend & $past(ack_bits) & ~$past(src)) == '0) &&
            ((pend & ~$past(ack_bits)) == (($past(pend) | $past(src)) & ~$past(ack_bits))));

endmodule

// File: rtl/hisc_irq_drive.sv
// Module: hisc_irq_drive
// Drives the host interrupt from unmasked pending bits, with polarity
// chosen by a static input. Purely combinational from the registers.
module hisc_irq_drive #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    input  logic               pol_low,
    output logic               irq
);

    logic any_live;

    // Purpose: reduce the unmasked pending bits and apply polarity.
    always_comb begin
        any_live = |(pend & ~mask);
        irq      = pol_low ? ~any_live : any_live;
    end

endmodule

// File: rtl/hisc_top.sv
// Module: hisc_top
// Host interrupt status controller: register decode, mask, pending status,
// registered read port and interrupt line. Assumes NUM_SRC <= DATA_W.
// Read data is loaded on each read strobe and holds otherwise.
module hisc_top
    import hisc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned DATA_W  = 16,
    parameter logic [NUM_SRC-1:0] MASK_RST = NUM_SRC'(1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     src_evt,
    input  logic [HISC_ADDR_W-1:0] bus_addr,
    input  logic                   bus_we,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic                   bus_re,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic                   irq_pol_low,
    output logic                   host_irq
);

    hisc_strobe_t       stb;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] pend;
    logic [DATA_W-1:0]  mask_ext;
    logic [DATA_W-1:0]  pend_ext;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  rdata_q;

    assign wbits = bus_wdata[NUM_SRC-1:0];

    hisc_decode u_dec (
        .we   (bus_we),
        .re   (bus_re),
        .addr (bus_addr),
        .stb  (stb)
    );

    hisc_mask_reg #(.NUM_SRC(NUM_SRC), .RST_VAL(MASK_RST)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_all (stb.mask_wr),
        .wr_set (stb.mask_set),
        .wr_clr (stb.mask_clr),
        .wbits  (wbits),
        .mask   (mask)
    );

    hisc_status_reg #(.NUM_SRC(NUM_SRC)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src_evt),
        .drain    (stb.drain_rd),
        .ack_we   (stb.ack_wr),
        .ack_bits (wbits),
        .pend     (pend)
    );

    hisc_irq_drive #(.NUM_SRC(NUM_SRC)) u_irq (
        .pend    (pend),
        .mask    (mask),
        .pol_low (irq_pol_low),
        .irq     (host_irq)
    );

    // Purpose: zero-extend mask and status to the bus width.
    always_comb begin
        mask_ext = '0;
        pend_ext = '0;
        mask_ext[NUM_SRC-1:0] = mask;
        pend_ext[NUM_SRC-1:0] = pend;
    end

    // Purpose: select read data; write-only and unmapped offsets read 0.
    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFS_MASK)                      rd_mux = mask_ext;
        else if (stb.peek_rd || stb.drain_rd)          rd_mux = pend_ext;
    end

    // Purpose: register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_re) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // R5: a side-effect-free read with no new events leaves status intact.
    assert_peek_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.peek_rd && !bus_we && src_evt == '0) |=> pend == $past(pend));

    // R6: a draining read returns the status held before the edge.
    assert_drain_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stb.drain_rd |=> bus_rdata == $past(pend_ext));

    // R10: with every source masked the line stays inactive.
    assert_all_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> host_irq == irq_pol_low);

    // R11: reads of write-only offsets return zero.
    assert_wo_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (bus_addr == OFS_MASK_SET || bus_addr == OFS_MASK_CLR ||
                    bus_addr == OFS_ACK)) |=> bus_rdata == '0);

endmodule

// File: tb/tb_hisc_top.sv
// Bench for hisc_top: a vector table walked once, then directed tests for
// interrupt polarity and a reset in mid-run.
module tb_hisc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_evt = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata;
    logic        irq_pol_low = 1'b0;
    logic        host_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hisc_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_evt     (src_evt),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_re      (bus_re),
        .bus_rdata   (bus_rdata),
        .irq_pol_low (irq_pol_low),
        .host_irq    (host_irq)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        chk_rd;
        logic        we;
        logic        re;
        logic [3:0]  addr;
        logic [15:0] wd;
        logic [15:0] src;
        logic [15:0] exp_rd;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 31;
    // Each row drives one cycle; results are sampled on the next falling edge.
    localparam vec_t TBL [NV] = '{
        '{4'd1,  1'b1, 1'b0, 1'b1, 4'h0, 16'h0000, 16'h0000, 16'h0001, 1'b0}, // R1 mask reset
        '{4'd1,  1'b1, 1'b0, 1'b1, 4'h3, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R1 status empty
        '{4'd9,  1'b0, 1'b0, 1'b0, 4'h0, 16'h0000, 16'h0001, 16'h0000, 1'b0}, // R9 masked event
        '{4'd9,  1'b1, 1'b0, 1'b1, 4'h3, 16'h0000, 16'h0000, 16'h0001, 1'b0}, // R9 visible
        '{4'd10, 1'b0, 1'b0, 1'b0, 4'h0, 16'h0000, 16'h0002, 16'h0000, 1'b1}, // R10 unmasked event
        '{4'd3,  1'b0, 1'b1, 1'b0, 4'h1, 16'h0002, 16'h0000, 16'h0000, 1'b0}, // R3 set bit1
        '{4'd3,  1'b1, 1'b0, 1'b1, 4'h0, 16'h0000, 16'h0000, 16'h0003, 1'b0}, // R3 readback
        '{4'd4,  1'b0, 1'b1, 1'b0, 4'h2, 16'h0001, 16'h0000, 16'h0000, 1'b1}, // R4 clear bit0
        '{4'd4,  1'b1, 1'b0, 1'b1, 4'h0, 16'h0000, 16'h0000, 16'h0002, 1'b1}, // R4 readback
        '{4'd2,  1'b0, 1'b1, 1'b0, 4'h0, 16'hFFFF, 16'h0000, 16'h0000, 1'b0}, // R2 mask all
        '{4'd2,  1'b1, 1'b0, 1'b1, 4'h0, 16'h0000, 16'h0000, 16'hFFFF, 1'b0}, // R2 readback
        '{4'd2,  1'b0, 1'b1, 1'b0, 4'h0, 16'h0000, 16'h0000, 16'h0000, 1'b1}, // R2 unmask all
        '{4'd12, 1'b0, 1'b0, 1'b0, 4'h0, 16'h0000, 16'h4400, 16'h0000, 1'b1}, // R12 bits 10,14
        '{4'd5,  1'b1, 1'b0, 1'b1, 4'h3, 16'h0000, 16'h0000, 16'h4403, 1'b1}, // R5 peek
        '{4'd5,  1'b1, 1'b0, 1'b1, 4'h3, 16'h0000, 16'h0000, 16'h4403, 1'b1}, // R5 unchanged
        '{4'd7,  1'b0, 1'b1, 1'b0, 4'h5, 16'h0401, 16'h0000, 16'h0000, 1'b1}, // R7 ack 10,0
        '{4'd7,  1'b1, 1'b0, 1'b1, 4'h3, 16'h0000, 16'h0000, 16'h4002, 1'b1}, // R7 rest kept
        '{4'd6,  1'b1, 1'b0, 1'b1, 4'h4, 16'h0000, 16'h0000, 16'h4002, 1'b0}, // R6 drain
        '{4'd6,  1'b1, 1'b0, 1'b1, 4'h3, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R6 empty
        '{4'd11, 1'b1, 1'b0, 1'b1, 4'h5, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R11 wo read
        '{4'd8,  1'b0, 1'b0, 1'b0, 4'h0, 16'h0000, 16'h0010, 16'h0000, 1'b1}, // R8 prime bit4
        '{4'd8,  1'b1, 1'b0, 1'b1, 4'h4, 16'h0000, 16'h0010, 16'h0010, 1'b1}, // R8 drain+event
        '{4'd8,  1'b1, 1'b0, 1'b1, 4'h3, 16'h0000, 16'h0000, 16'h0010, 1'b1}, // R8 still set
        '{4'd8,  1'b0, 1'b1, 1'b0, 4'h5, 16'h0010, 16'h0010, 16'h0000, 1'b1}, // R8 ack+event
        '{4'd8,  1'b1, 1'b0, 1'b1, 4'h3, 16'h0000, 16'h0000, 16'h0010, 1'b1}, // R8 still set
        '{4'd11, 1'b0, 1'b1, 1'b0, 4'h3, 16'hFFFF, 16'h0000, 16'h0000, 1'b1}, // R11 write peek
        '{4'd11, 1'b1, 1'b0, 1'b1, 4'h3, 16'h0000, 16'h0000, 16'h0010, 1'b1}, // R11 no change
        '{4'd11, 1'b0, 1'b1, 1'b0, 4'h4, 16'hFFFF, 16'h0000, 16'h0000, 1'b1}, // R11 write drain
        '{4'd11, 1'b1, 1'b0, 1'b1, 4'h3, 16'h0000, 16'h0000, 16'h0010, 1'b1}, // R11 no change
        '{4'd7,  1'b0, 1'b1, 1'b0, 4'h5, 16'h0010, 16'h0000, 16'h0000, 1'b0}, // R7 ack last
        '{4'd7,  1'b1, 1'b0, 1'b1, 4'h3, 16'h0000, 16'h0000, 16'h0000, 1'b0}  // R7 empty
    };

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Drive one cycle from the falling edge; return at the next falling edge.
    task automatic drive(input logic we, input logic re, input logic [3:0] addr,
                         input logic [15:0] wd, input logic [15:0] src);
        bus_we = we; bus_re = re; bus_addr = addr; bus_wdata = wd; src_evt = src;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0; src_evt = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            drive(TBL[k].we, TBL[k].re, TBL[k].addr, TBL[k].wd, TBL[k].src);
            if (TBL[k].chk_rd)
                check16($sformatf("R%0d row %0d rdata", TBL[k].req, k), bus_rdata, TBL[k].exp_rd);
            check1($sformatf("R%0d row %0d irq", TBL[k].req, k), host_irq, TBL[k].exp_irq);
        end

        // R10 polarity: mask is 0 and status empty here, so the line is inactive.
        irq_pol_low = 1'b1;
        #2 check1("R10 active-low idle", host_irq, 1'b1);
        @(negedge clk);
        drive(1'b0, 1'b0, 4'h0, 16'h0000, 16'h0100);
        check1("R10 active-low asserted", host_irq, 1'b0);
        irq_pol_low = 1'b0;
        #2 check1("R10 active-high asserted", host_irq, 1'b1);
        @(negedge clk);

        // R1: reset mid-run restores mask and empties status.
        drive(1'b1, 1'b0, 4'h0, 16'h00F0, 16'h0000);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check1("R1 irq after reset", host_irq, 1'b0);
        drive(1'b0, 1'b1, 4'h0, 16'h0000, 16'h0000);
        check16("R1 mask after reset", bus_rdata, 16'h0001);
        drive(1'b0, 1'b1, 4'h3, 16'h0000, 16'h0000);
        check16("R1 status after reset", bus_rdata, 16'h0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule